// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a set of nodes and hands the CPU one winner at a time. The winner comes as a node index, used as the vector number, together with its priority level. Each node owns a small control word that software reads and writes through a synchronous register port. The word holds a pending flag, an enable flag and a 4-bit priority level.

A peripheral raises a node's pending flag with a one-cycle pulse. Software can raise the same flag by writing it, which is how nodes without a peripheral produce software interrupts.

The controller keeps the level currently being serviced. It offers a new request only when an enabled, pending node has a level strictly above that level. When the CPU accepts the request, the current level is saved on an internal level stack and the winner's level becomes the current level. On return from the handler, the saved level is restored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A control word is laid out as bit 5 = pending, bit 4 = enable, bits 3:0 = level.
  - A write with `reg_wr` takes effect at that clock edge.
  - A read with `reg_rd` returns, one edge later on `reg_rdata`, the word as it was before that edge.
  - Addresses at or above the node count read as zero, and writes to them change nothing.
- R2: After reset, every control word, `irq_req` and `cur_lvl` are zero.
- R3: A node whose level is 0, or whose enable flag is 0, never causes `irq_req`.
- R4: Among enabled, pending, nonzero-level nodes, the highest level wins. On a tie, the lowest index wins. `irq_vec` shows the winner's index and `irq_lvl` its level.
- R5: `irq_req` is raised only when the winning level is strictly greater than `cur_lvl`. An equal level does not preempt.
- R6: An `irq_ack` while `irq_req` is high has these effects:
  - it clears the pending flag of the presented node;
  - it saves the old current level;
  - it makes `irq_lvl` the new `cur_lvl`;
  - `irq_req` is low in the cycle that follows.
- R7: `irq_ret` does the following:
  - it restores the most recently saved level into `cur_lvl`;
  - with nothing saved, it leaves `cur_lvl` unchanged;
  - `irq_req` is low in the cycle that follows, then is evaluated again against the restored level.
- R8: A pending flag is set by a software write of bit 5 or by a `hw_set` pulse. A `hw_set` pulse in the same cycle as an acknowledge of that node keeps the flag set.
- R9: A flag set at clock edge k shows up on `irq_req` after edge k+1.
- R10: An `irq_ack` while `irq_req` is low changes neither `cur_lvl` nor any control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word at `reg_addr` |
| reg_rd | input | 1 | Read strobe for the control word at `reg_addr` |
| reg_addr | input | AW | Node index of the access |
| reg_wdata | input | 6 | Control word to write |
| reg_rdata | output | 6 | Control word read, valid one edge after `reg_rd` |
| hw_set | input | NODES | Per-node pulse that sets the pending flag |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | AW | Vector number (node index) of the presented request |
| irq_lvl | output | 4 | Priority level of the presented request |
| irq_ack | input | 1 | CPU accepts the presented request |
| irq_ret | input | 1 | CPU returns from the current handler |
| cur_lvl | output | 4 | Level currently being serviced |

## Verification
Arbitration is swept over every ordered pair of nodes in a six-node configuration, across all sixteen levels of each. The enable flag is varied in a pattern, so one sweep separates the effect of level zero, of a disabled node, of a strictly higher level and of the index tie-break.

A directed nesting sequence covers the rest:
- an equal level that must not preempt;
- a higher level that must preempt;
- returns that restore levels in order, and a return with nothing saved;
- an acknowledge with no request pending;
- a hardware set that collides with an acknowledge.

Single-cycle pulses on `hw_set` pin down the two-edge latency. Out-of-range addresses show that reads return zero and that writes are dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned LVL_W   = 4;
   localparam int unsigned NUM_LVL = 1 << LVL_W;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef struct packed {
      logic req;
      logic en;
      lvl_t lvl;
   } node_ctl_t;

   localparam int unsigned CTL_W = $bits(node_ctl_t);
endpackage

// File: rtl/irqc_node.sv
module irqc_node
   import irqc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  node_ctl_t wdata,
   input  logic      hw_set,
   input  logic      ack_clr,
   output node_ctl_t ctl,
   output logic      cand
);
   node_ctl_t nxt;

   always_comb begin
      nxt = wr_en ? wdata : ctl;
      if (ack_clr) nxt.req = 1'b0;
      if (hw_set)  nxt.req = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctl <= '0;
      else        ctl <= nxt;
   end

   assign cand = ctl.req && ctl.en && (ctl.lvl != '0);

   // R8: a set pulse always leaves the pending flag high
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> ctl.req);
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
   import irqc_pkg::*;
#(
   parameter int unsigned NODES = 63,
   parameter int unsigned AW    = 6
)(
   input  logic [NODES-1:0] cand,
   input  lvl_t             lvls [NODES],
   output logic             found,
   output logic [AW-1:0]    win_idx,
   output lvl_t             win_lvl
);
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = NODES - 1; i >= 0; i--) begin
         if (cand[i] && (lvls[i] >= win_lvl)) begin
            found   = 1'b1;
            win_lvl = lvls[i];
            win_idx = AW'(i);
         end
      end
   end
endmodule

// File: rtl/irqc_lvlstack.sv
module irqc_lvlstack
   import irqc_pkg::*;
#(
   parameter int unsigned DEPTH = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic pop,
   input  lvl_t push_lvl,
   output lvl_t cur_lvl,
   output logic empty,
   output logic full
);
   localparam int unsigned PW = $clog2(DEPTH + 1);

   lvl_t          saved [DEPTH];
   logic [PW-1:0] ptr;
   logic          do_pop;

   assign empty  = (ptr == '0);
   assign full   = (ptr == PW'(DEPTH));
   assign do_pop = pop && !push && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr     <= '0;
         cur_lvl <= '0;
      end else if (push && !full) begin
         ptr     <= ptr + 1'b1;
         cur_lvl <= push_lvl;
      end else if (do_pop) begin
         ptr     <= ptr - 1'b1;
         cur_lvl <= saved[ptr - 1'b1];
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) saved[ptr] <= cur_lvl;
   end

   // R5: strict preemption bounds nesting below the stack depth
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R7: a restored level is always below the one it replaces
   assert_pop_lowers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      do_pop |=> cur_lvl < $past(cur_lvl));

   // R6: an accepted request raises the current level
   assert_push_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> cur_lvl > $past(cur_lvl));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NODES       = 63,
   parameter int unsigned STACK_DEPTH = 16,
   localparam int unsigned AW         = (NODES > 1) ? $clog2(NODES) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [AW-1:0]    reg_addr,
   input  logic [CTL_W-1:0] reg_wdata,
   output logic [CTL_W-1:0] reg_rdata,
   input  logic [NODES-1:0] hw_set,
   output logic             irq_req,
   output logic [AW-1:0]    irq_vec,
   output logic [LVL_W-1:0] irq_lvl,
   input  logic             irq_ack,
   input  logic             irq_ret,
   output logic [LVL_W-1:0] cur_lvl
);
   if (NODES < 2) begin : g_bad_nodes
      $error("NODES must be at least 2");
   end
   if (STACK_DEPTH < NUM_LVL - 1) begin : g_bad_depth
      $error("STACK_DEPTH must cover every nonzero level");
   end

   node_ctl_t        ctl  [NODES];
   lvl_t             lvls [NODES];
   logic [NODES-1:0] cand;
   logic             found;
   logic [AW-1:0]    win_idx;
   lvl_t             win_lvl;
   logic             ack_ok;
   logic             stk_empty;
   logic             stk_full;
   lvl_t             cur_q;

   assign ack_ok = irq_ack && irq_req;

   for (genvar i = 0; i < NODES; i++) begin : g_node
      irqc_node u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_wr && (reg_addr == AW'(i))),
         .wdata   (node_ctl_t'(reg_wdata)),
         .hw_set  (hw_set[i]),
         .ack_clr (ack_ok && (irq_vec == AW'(i))),
         .ctl     (ctl[i]),
         .cand    (cand[i])
      );
      assign lvls[i] = ctl[i].lvl;
   end

   irqc_arb #(.NODES(NODES), .AW(AW)) u_arb (
      .cand    (cand),
      .lvls    (lvls),
      .found   (found),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   irqc_lvlstack #(.DEPTH(STACK_DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_ok),
      .pop      (irq_ret),
      .push_lvl (irq_lvl),
      .cur_lvl  (cur_q),
      .empty    (stk_empty),
      .full     (stk_full)
   );
   assign cur_lvl = cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
         irq_lvl <= '0;
      end else begin
         irq_req <= found && (win_lvl > cur_q) && !ack_ok && !irq_ret;
         irq_vec <= win_idx;
         irq_lvl <= win_lvl;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         if (32'(reg_addr) < NODES) reg_rdata <= ctl[reg_addr];
         else                       reg_rdata <= '0;
      end
   end

   // R5: a presented request always outranks the serviced level
   assert_strict_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl > cur_lvl);

   // R3: level zero never reaches the CPU
   assert_lvl0_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_lvl != '0);

   // R6: acceptance takes the presented level and drops the request
   assert_ack_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok |=> (cur_lvl == $past(irq_lvl)) && !irq_req);

   // R10: an acknowledge without a request leaves the level alone
   assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !irq_req && !irq_ret) |=> $stable(cur_lvl));

   // R7: the request drops the cycle after a return
   assert_ret_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ret |=> !irq_req);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
   localparam int NODES = 6;
   localparam int AW    = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic             reg_rd = 1'b0;
   logic [AW-1:0]    reg_addr = '0;
   logic [5:0]       reg_wdata = '0;
   logic [5:0]       reg_rdata;
   logic [NODES-1:0] hw_set = '0;
   logic             irq_req;
   logic [AW-1:0]    irq_vec;
   logic [3:0]       irq_lvl;
   logic             irq_ack = 1'b0;
   logic             irq_ret = 1'b0;
   logic [3:0]       cur_lvl;

   int nchk = 0;
   int nbad = 0;

   always #4 clk = ~clk;

   prio_irq_ctrl #(.NODES(NODES), .STACK_DEPTH(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hw_set(hw_set), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_lvl(irq_lvl), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .cur_lvl(cur_lvl)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 6'(d);
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_rd = 1'b1; reg_addr = AW'(a);
      tick();
      reg_rd = 1'b0;
      d = int'(reg_rdata);
   endtask

   task automatic ack();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1; tick(); irq_ret = 1'b0;
   endtask

   function automatic int word(input int rq, input int en, input int l);
      return (rq << 5) | (en << 4) | l;
   endfunction

   initial begin
      #(8 * 190000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      chk("R2 irq_req", int'(irq_req), 0);
      chk("R2 cur_lvl", int'(cur_lvl), 0);
      for (int n = 0; n < NODES; n++) begin
         rd(n, d);
         chk("R2 word", d, 0);
      end

      // R1 register port
      wr(3, word(0, 1, 10));
      rd(3, d); chk("R1 readback", d, word(0, 1, 10));
      wr(7, word(1, 1, 9));
      rd(7, d); chk("R1 out of range read", d, 0);
      tick();
      chk("R1 out of range write no irq", int'(irq_req), 0);

      // R10 ack with no request
      ack();
      chk("R10 cur_lvl", int'(cur_lvl), 0);
      rd(3, d); chk("R10 word", d, word(0, 1, 10));

      // R9 latency of a set pulse, R8 hardware set
      hw_set[3] = 1'b1; tick(); hw_set[3] = 1'b0;
      chk("R9 not yet", int'(irq_req), 0);
      tick();
      chk("R9 irq_req", int'(irq_req), 1);
      chk("R4 vec", int'(irq_vec), 3);
      chk("R4 lvl", int'(irq_lvl), 10);
      rd(3, d); chk("R8 hw set flag", d, word(1, 1, 10));

      // R6 acknowledge
      ack();
      chk("R6 req low", int'(irq_req), 0);
      chk("R6 cur_lvl", int'(cur_lvl), 10);
      rd(3, d); chk("R6 flag cleared", d, word(0, 1, 10));

      // R5 equal does not preempt, higher does
      wr(4, word(1, 1, 10)); tick();
      chk("R5 equal level", int'(irq_req), 0);
      wr(5, word(1, 1, 11)); tick();
      chk("R5 higher req", int'(irq_req), 1);
      chk("R5 higher vec", int'(irq_vec), 5);
      ack();
      chk("R6 nested cur", int'(cur_lvl), 11);

      // R7 returns
      ret();
      chk("R7 pop cur", int'(cur_lvl), 10);
      chk("R7 gap", int'(irq_req), 0);
      tick();
      chk("R7 equal after pop", int'(irq_req), 0);
      ret();
      chk("R7 pop to zero", int'(cur_lvl), 0);
      chk("R7 gap2", int'(irq_req), 0);
      tick();
      chk("R7 reeval req", int'(irq_req), 1);
      chk("R7 reeval vec", int'(irq_vec), 4);
      ack();
      chk("R6 cur after ack", int'(cur_lvl), 10);
      ret();
      ret();
      chk("R7 empty ret", int'(cur_lvl), 0);
      tick();
      chk("R7 nothing left", int'(irq_req), 0);

      // R8 set pulse collides with acknowledge
      wr(1, word(1, 1, 7)); tick();
      chk("R8 pre req", int'(irq_req), 1);
      chk("R8 pre vec", int'(irq_vec), 1);
      irq_ack = 1'b1; hw_set[1] = 1'b1; tick();
      irq_ack = 1'b0; hw_set[1] = 1'b0;
      rd(1, d); chk("R8 set beats clear", d, word(1, 1, 7));
      chk("R8 cur", int'(cur_lvl), 7);
      ret();
      for (int n = 0; n < NODES; n++) wr(n, 0);
      tick();

      // R3 / R4 pair sweep
      for (int i = 0; i < NODES; i++) begin
         for (int j = 0; j < NODES; j++) begin
            if (i == j) continue;
            for (int li = 0; li < 16; li++) begin
               for (int lj = 0; lj < 16; lj++) begin
                  int ei, ej, ci, cj, er, ev, el;
                  ei = ((li + i) % 4 != 0) ? 1 : 0;
                  ej = ((lj + j + 1) % 5 != 0) ? 1 : 0;
                  ci = (ei == 1 && li != 0) ? 1 : 0;
                  cj = (ej == 1 && lj != 0) ? 1 : 0;
                  er = (ci | cj);
                  ev = 0; el = 0;
                  if (ci == 1 && (cj == 0 || li > lj || (li == lj && i < j))) begin
                     ev = i; el = li;
                  end else if (cj == 1) begin
                     ev = j; el = lj;
                  end
                  wr(i, word(1, ei, li));
                  wr(j, word(1, ej, lj));
                  tick();
                  chk("R3 R4 sweep req", int'(irq_req), er);
                  if (er == 1) begin
                     chk("R4 sweep vec", int'(irq_vec), ev);
                     chk("R4 sweep lvl", int'(irq_lvl), el);
                  end
                  wr(i, 0);
                  wr(j, 0);
               end
            end
         end
      end

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule